// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block is the digital front end of a 16-bit voltage-output converter. A host writes 24-bit frames over a three-wire link: an active-low frame strobe, a serial clock and a data line. The block brings these pins into the system clock domain and takes one data bit on each falling edge of the serial clock while the strobe is low.

On the 24th falling edge it stores the 16-bit code and a 2-bit power-down mode together. If the strobe rises before then, the frame is dropped and nothing changes. The stored code then drives the switch controls of a segmented converter. The top four code bits become a 15-line thermometer word. The lower twelve bits drive twelve binary ladder switches directly.

The system clock must run at least four times faster than the serial clock. Each input passes through a two-flop synchroniser, and edges are detected in the system clock domain.

Top module: `dac_frame_rx`

## Requirements
- R1: After reset the stored code is 0x8000 (midscale) and the mode is 2'b00. The thermometer output is therefore 15'h00FF and the ladder output is 0.
- R2: A frame is sent MSB first. Bits [17:16] of the 24-bit word are the mode and bits [15:0] are the code. Both are stored together on the 24th falling serial clock edge after a falling edge of the strobe.
- R3: Each of the four mode values is stored unchanged: 00 normal, 01 output to ground through 1 kΩ, 10 output to ground through 100 kΩ, 11 output high-impedance.
- R4: If the strobe rises before the 24th falling edge, the frame is dropped. Neither the code nor the mode changes.
- R5: A dropped frame leaves no partial bits behind. The next complete frame is stored exactly as sent.
- R6: The frame is stored on the 24th edge even if the strobe stays low. Further falling edges in the same low period are ignored. A new frame starts only after the strobe rises and falls again.
- R7: Bits [23:18] of a frame have no effect on any output.
- R8: Serial clock edges while the strobe is high have no effect on any output.
- R9: Thermometer bit i (0..14) is 1 exactly when the top four code bits, read as a number, exceed i.
- R10: The ladder output equals code bits [11:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| sync_n | input | 1 | Active-low frame strobe, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous; data is taken on its falling edges |
| sdin | input | 1 | Serial data, MSB first |
| dac_code | output | 16 | Stored converter code |
| pd_mode | output | 2 | Stored power-down mode |
| seg_therm | output | 15 | Thermometer switch controls for the top four code bits |
| lad_bits | output | 12 | Binary ladder switch controls |

## Verification
The properties assume the serial pins change slowly compared with the system clock. Each level of the serial clock, the data line around a falling edge, and each strobe level must last several system cycles. Under that assumption, every detected falling edge sees settled data.

The bench runs the serial clock with half-periods of four system cycles. It changes the data line only while the serial clock is high. It moves the strobe only while the serial clock is high and idle, and keeps the strobe high for a full half-period between frames.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;

  localparam int unsigned FRAME_BITS = 24;
  localparam int unsigned CODE_BITS  = 16;
  localparam int unsigned MODE_BITS  = 2;
  localparam int unsigned SEG_MSBS   = 4;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    PD_NORMAL = 2'b00,
    PD_GND_1K = 2'b01,
    PD_GND_100K = 2'b10,
    PD_HIGHZ = 2'b11
  } pd_mode_e;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SHIFT = 2'd1,
    FR_DONE  = 2'd2
  } frame_st_e;

endpackage

// File: rtl/dac_rx_sync.sv
module dac_rx_sync #(
  parameter int unsigned CTL_W  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [CTL_W-1:0] CTL_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             dat_i,
  output logic [CTL_W-1:0] ctl_lvl,
  output logic [CTL_W-1:0] ctl_fall,
  output logic             dat_lvl
);

  localparam int unsigned VEC_W = CTL_W + 1;
  localparam logic [VEC_W-1:0] VEC_RST = {1'b0, CTL_RST};

  logic [VEC_W-1:0] stage_q [STAGES];
  logic [VEC_W-1:0] stage_d [STAGES];
  logic [CTL_W-1:0] prev_q;
  logic [CTL_W-1:0] prev_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb stage_d[g] = {dat_i, ctl_i};
      end else begin : g_next
        always_comb stage_d[g] = stage_q[g-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= VEC_RST;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  always_comb prev_d = stage_q[STAGES-1][CTL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= CTL_RST;
    else        prev_q <= prev_d;
  end

  always_comb begin
    ctl_lvl  = stage_q[STAGES-1][CTL_W-1:0];
    dat_lvl  = stage_q[STAGES-1][CTL_W];
    ctl_fall = prev_q & ~ctl_lvl;
  end

endmodule

// File: rtl/dac_rx_shifter.sv
module dac_rx_shifter
  import dac_rx_pkg::*;
#(
  parameter int unsigned FRAME_W   = 24,
  parameter int unsigned PAYLOAD_W = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_lvl,
  input  logic                 sync_fall,
  input  logic                 sclk_fall,
  input  logic                 din_bit,
  output frame_st_e            state,
  output logic                 commit,
  output logic [PAYLOAD_W-1:0] payload
);

  localparam int unsigned CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);
  localparam int unsigned HOLD_W = PAYLOAD_W - 1;

  frame_st_e          st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [HOLD_W-1:0]  hold_q, hold_d;
  logic               commit_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    hold_d   = hold_q;
    commit_d = 1'b0;
    unique case (st_q)
      FR_IDLE: begin
        if (sync_fall) begin
          st_d   = FR_SHIFT;
          cnt_d  = '0;
          hold_d = '0;
        end
      end
      FR_SHIFT: begin
        if (sync_lvl) begin
          st_d   = FR_IDLE;
          cnt_d  = '0;
          hold_d = '0;
        end else if (sclk_fall) begin
          hold_d = {hold_q[HOLD_W-2:0], din_bit};
          if (cnt_q == LAST_IDX) begin
            commit_d = 1'b1;
            st_d     = FR_DONE;
            cnt_d    = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      FR_DONE: begin
        if (sync_lvl) st_d = FR_IDLE;
      end
      default: st_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  always_comb begin
    state   = st_q;
    commit  = commit_d;
    payload = {hold_q, din_bit};
  end

endmodule

// File: rtl/dac_rx_regs.sv
module dac_rx_regs #(
  parameter int unsigned CODE_W = 16,
  parameter int unsigned MODE_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_en,
  input  logic [CODE_W+MODE_W-1:0]   payload,
  output logic [CODE_W-1:0]          code,
  output logic [MODE_W-1:0]          mode
);

  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [MODE_W-1:0] MODE_RST = '0;

  logic [CODE_W-1:0] code_q, code_d;
  logic [MODE_W-1:0] mode_q, mode_d;

  always_comb begin
    code_d = code_q;
    mode_d = mode_q;
    if (load_en) begin
      code_d = payload[CODE_W-1:0];
      mode_d = payload[CODE_W +: MODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= MID_CODE;
      mode_q <= MODE_RST;
    end else begin
      code_q <= code_d;
      mode_q <= mode_d;
    end
  end

  assign code = code_q;
  assign mode = mode_q;

endmodule

// File: rtl/dac_rx_decode.sv
module dac_rx_decode #(
  parameter int unsigned CODE_W = 16,
  parameter int unsigned SEG_W  = 4
) (
  input  logic [CODE_W-1:0]          code,
  output logic [(1<<SEG_W)-2:0]      therm,
  output logic [CODE_W-SEG_W-1:0]    ladder
);

  localparam int unsigned THERM_W = (1 << SEG_W) - 1;
  localparam int unsigned LAD_W   = CODE_W - SEG_W;

  logic [SEG_W-1:0] seg_val;

  assign seg_val = code[CODE_W-1 -: SEG_W];

  genvar t;
  generate
    for (t = 0; t < THERM_W; t++) begin : g_therm
      assign therm[t] = (seg_val > SEG_W'(t));
    end
  endgenerate

  assign ladder = code[LAD_W-1:0];

endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
  import dac_rx_pkg::*;
#(
  parameter int unsigned FRAME_W = FRAME_BITS,
  parameter int unsigned CODE_W  = CODE_BITS,
  parameter int unsigned MODE_W  = MODE_BITS,
  parameter int unsigned SEG_W   = SEG_MSBS,
  parameter int unsigned STAGES  = SYNC_STAGES
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sync_n,
  input  logic                          sclk,
  input  logic                          sdin,
  output logic [CODE_W-1:0]             dac_code,
  output logic [MODE_W-1:0]             pd_mode,
  output logic [(1<<SEG_W)-2:0]         seg_therm,
  output logic [CODE_W-SEG_W-1:0]       lad_bits
);

  localparam int unsigned PAYLOAD_W = CODE_W + MODE_W;
  localparam int unsigned IDX_SYNC  = 0;
  localparam int unsigned IDX_SCLK  = 1;

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [1:0] ctl_lvl, ctl_fall;
  logic       din_lvl;
  logic       sync_lvl, sync_fall, sclk_fall;

  dac_rx_sync #(
    .CTL_W   (2),
    .STAGES  (STAGES),
    .CTL_RST (2'b11)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ctl_i    ({sclk, sync_n}),
    .dat_i    (sdin),
    .ctl_lvl  (ctl_lvl),
    .ctl_fall (ctl_fall),
    .dat_lvl  (din_lvl)
  );

  assign sync_lvl  = ctl_lvl[IDX_SYNC];
  assign sync_fall = ctl_fall[IDX_SYNC];
  assign sclk_fall = ctl_fall[IDX_SCLK];

  frame_st_e            fr_state;
  logic                 commit;
  logic [PAYLOAD_W-1:0] payload;

  dac_rx_shifter #(
    .FRAME_W   (FRAME_W),
    .PAYLOAD_W (PAYLOAD_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sync_lvl  (sync_lvl),
    .sync_fall (sync_fall),
    .sclk_fall (sclk_fall),
    .din_bit   (din_lvl),
    .state     (fr_state),
    .commit    (commit),
    .payload   (payload)
  );

  dac_rx_regs #(
    .CODE_W (CODE_W),
    .MODE_W (MODE_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_en (commit),
    .payload (payload),
    .code    (dac_code),
    .mode    (pd_mode)
  );

  dac_rx_decode #(
    .CODE_W (CODE_W),
    .SEG_W  (SEG_W)
  ) u_dec (
    .code   (dac_code),
    .therm  (seg_therm),
    .ladder (lad_bits)
  );

endmodule

// File: rtl/dac_frame_rx_chk.sv
module dac_frame_rx_chk
  import dac_rx_pkg::*;
#(
  parameter int unsigned CODE_W = 16,
  parameter int unsigned MODE_W = 2,
  parameter int unsigned SEG_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CODE_W-1:0]         dac_code,
  input  logic [MODE_W-1:0]         pd_mode,
  input  logic [(1<<SEG_W)-2:0]     seg_therm,
  input  frame_st_e                 fr_state,
  input  logic                      sync_lvl,
  input  logic                      sclk_fall,
  input  logic                      commit
);

  logic edge_seen;
  always @(posedge clk) edge_seen <= 1'b1;

  // R1: reset value is held while reset is asserted
  always @(negedge clk) begin
    if (edge_seen === 1'b1 && !rst_n) begin
      a_r1_reset_value: assert (dac_code == {1'b1, {(CODE_W-1){1'b0}}} && pd_mode == '0);
    end
  end

  // R2: stored values change only after a frame commit
  a_r2_update_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code) || pd_mode != $past(pd_mode)) |-> $past(commit));

  // R4: dropping a frame leaves the stored values alone
  a_r4_abort_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_state == FR_SHIFT && sync_lvl) |=> ($stable(dac_code) && $stable(pd_mode)));

  // R6: no second commit inside one strobe-low period
  a_r6_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_state == FR_DONE) |-> !commit);

  // R8: clock edges outside a frame do nothing
  a_r8_idle_edges_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && fr_state != FR_SHIFT) |=> ($stable(dac_code) && $stable(pd_mode)));

  // R9: thermometer word is contiguous and its weight matches the top bits
  a_r9_therm_shape: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_therm & (seg_therm + 1'b1)) == '0) &&
    ($countones(seg_therm) == int'(dac_code[CODE_W-1 -: SEG_W])));

endmodule

bind dac_frame_rx dac_frame_rx_chk #(
  .CODE_W (CODE_W),
  .MODE_W (MODE_W),
  .SEG_W  (SEG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dac_code  (dac_code),
  .pd_mode   (pd_mode),
  .seg_therm (seg_therm),
  .fr_state  (fr_state),
  .sync_lvl  (sync_lvl),
  .sclk_fall (sclk_fall),
  .commit    (commit)
);

// File: tb/dac_frame_rx_tb.sv
module dac_frame_rx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SCLK_HALF  = 4 * CLK_PERIOD;

  logic        clk;
  logic        rst_n;
  logic        sync_n;
  logic        sclk;
  logic        sdin;
  logic [15:0] dac_code;
  logic [1:0]  pd_mode;
  logic [14:0] seg_therm;
  logic [11:0] lad_bits;

  dac_frame_rx u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_n    (sync_n),
    .sclk      (sclk),
    .sdin      (sdin),
    .dac_code  (dac_code),
    .pd_mode   (pd_mode),
    .seg_therm (seg_therm),
    .lad_bits  (lad_bits)
  );

  typedef struct {
    logic [15:0] code;
    logic [1:0]  mode;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  int          checks;
  int          fails;
  logic [15:0] mdl_code;
  logic [1:0]  mdl_mode;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_val(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [14:0] therm_of(input logic [15:0] c);
    logic [14:0] t;
    for (int i = 0; i < 15; i++) t[i] = (int'(c[15:12]) > i);
    return t;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // monitor: pop expected item and compare against the ports
  initial begin
    exp_t e;
    forever begin
      wait (exp_q.size() > 0);
      repeat (4) @(posedge clk);
      @(negedge clk);
      e = exp_q[0];
      check_val(e.tag, "code", 32'(dac_code), 32'(e.code));
      check_val(e.tag, "mode", 32'(pd_mode), 32'(e.mode));
      check_val({e.tag, "/R9"}, "therm", 32'(seg_therm), 32'(therm_of(e.code)));
      check_val({e.tag, "/R10"}, "ladder", 32'(lad_bits), 32'(e.code[11:0]));
      void'(exp_q.pop_front());
    end
  end

  task automatic expect_now(input string tag);
    exp_q.push_back('{mdl_code, mdl_mode, tag});
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  // drives n bits MSB first; the strobe falls only if it is high on entry
  task automatic send_bits(input logic [23:0] w, input int n, input bit raise);
    sync_n = 1'b0;
    #(SCLK_HALF);
    for (int i = 0; i < n; i++) begin
      sdin = w[23-i];
      #(SCLK_HALF);
      sclk = 1'b0;
      #(SCLK_HALF);
      sclk = 1'b1;
    end
    #(SCLK_HALF);
    if (raise) begin
      sync_n = 1'b1;
      #(SCLK_HALF);
    end
  endtask

  task automatic full_frame(input logic [5:0] dc, input logic [1:0] m,
                            input logic [15:0] d, input string tag);
    send_bits({dc, m, d}, 24, 1'b1);
    mdl_code = d;
    mdl_mode = m;
    expect_now(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not finish");
    finish_run();
  end

  initial begin
    checks = 0;
    fails  = 0;
    rst_n  = 1'b0;
    sync_n = 1'b1;
    sclk   = 1'b1;
    sdin   = 1'b0;
    mdl_code = 16'h8000;
    mdl_mode = 2'b00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    expect_now("R1");

    // R2 basic frame
    full_frame(6'h00, 2'b00, 16'h1234, "R2");
    full_frame(6'h00, 2'b00, 16'hC3A5, "R2");

    // R3 all mode values
    full_frame(6'h00, 2'b01, 16'hFFFF, "R3");
    full_frame(6'h00, 2'b10, 16'h0000, "R3");
    full_frame(6'h00, 2'b11, 16'h7FFF, "R3");
    full_frame(6'h00, 2'b00, 16'h5A5A, "R3");

    // R4 early strobe rise, short and one bit short
    send_bits({6'h00, 2'b11, 16'hFFFF}, 10, 1'b1);
    expect_now("R4");
    send_bits({6'h00, 2'b01, 16'h0F0F}, 23, 1'b1);
    expect_now("R4");

    // R5 no leftovers after an abort
    send_bits({6'h3F, 2'b11, 16'hFFFF}, 17, 1'b1);
    full_frame(6'h00, 2'b10, 16'h0001, "R5");

    // R7 don't-care leading bits
    full_frame(6'h3F, 2'b01, 16'hA5A5, "R7");
    full_frame(6'h2A, 2'b00, 16'h8001, "R7");

    // R6 strobe held low, commit then ignore further edges
    send_bits({6'h00, 2'b10, 16'h4321}, 24, 1'b0);
    mdl_code = 16'h4321;
    mdl_mode = 2'b10;
    expect_now("R6");
    send_bits({6'h00, 2'b11, 16'hEEEE}, 24, 1'b1);
    expect_now("R6");

    // R8 serial clock toggling with the strobe high
    for (int i = 0; i < 30; i++) begin
      sdin = i[0];
      #(SCLK_HALF);
      sclk = 1'b0;
      #(SCLK_HALF);
      sclk = 1'b1;
    end
    #(SCLK_HALF);
    expect_now("R8");
    full_frame(6'h00, 2'b01, 16'h0FF0, "R8");

    // R9 / R10 sweep over all top-nibble values
    for (int n = 0; n < 16; n++) begin
      full_frame(6'h00, 2'b00, {4'(n), 12'(n * 273 + 5)}, "R9");
    end

    finish_run();
  end

endmodule